// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps time of day and a full calendar in packed BCD registers that advance once per second. A clock enable at 32.768 kHz is divided down by a parameterised prescaler to make the one-second tick. The tick then ripples through seconds, minutes, hours, day of week, date, month and a two-digit year. Month lengths, including a 29th of February in leap years, are applied in hardware without software action.

A century flag is stored in the hours register and toggles each time the year wraps from 99 to 00. A single-cycle write port sets any register directly, and a combinational read port returns the current value of the addressed register. Register addresses follow the carry order of the counters.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 00, the century flag is 0, the day of week reads 01, and date and month read 01.
- R2: Seconds advance exactly once per PRESCALE cycles in which `tick_32k_i` is high. Cycles with `tick_32k_i` low neither count nor change any register.
- R3: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count 00 to 59 in BCD. Seconds wrapping from 59 advances minutes, and minutes wrapping from 59 advances hours.
- R4: Hours (address 2, bits 5:0) count 00 to 23 in BCD. Wrapping from 23 advances both the day of week and the date.
- R5: Day of week (address 3, bits 2:0) counts 1 to 7 and wraps from 7 to 1.
- R6: Date (address 4, bits 5:0) wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12. It wraps after 30 in months 04, 06, 09 and 11, and after 28 in February of a non-leap year. Each wrap advances the month.
- R7: In a leap year, February runs to 29 before wrapping. A year is a leap year when its BCD value is divisible by 4, and year 00 counts as a leap year.
- R8: Month (address 5, bits 4:0) counts 01 to 12 and wraps to 01. Each wrap advances the BCD year (address 6, bits 7:0), which counts 00 to 99.
- R9: The century flag (address 2, bit 6) toggles when the year wraps from 99 to 00.
- R10: A write (`wr_en_i` high) loads the addressed register on the next clock edge and overrides any advance of that register in the same cycle. All other registers still advance from their previous values. A write to hours sets the century flag from data bit 6.
- R11: A write to seconds clears the prescaler and suppresses the tick in that cycle, so the next tick comes PRESCALE enabled cycles later.
- R12: Address 7 reads 00, and a write to address 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_32k_i | input | 1 | 32.768 kHz clock enable, one cycle per reference period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 8 | Write data, packed BCD |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 8 | Read data for `rd_addr_i`, packed BCD |

## Verification
The counters are first run with the enable held high, and then with it gated every other cycle. This separates correct prescaling from counting of raw clocks. Directed writes place the calendar just before the end of a 30-day month, of February in a common year, of February in a year divisible by four and in year 00, and of December 99. Each case tells a different month-length or leap decision apart, and the last also covers the century flip. Writes issued while the prescaler is at its terminal count, writes to seconds, and writes to the unused address show write priority, the prescaler clear and the ignored address against a behavioural model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    ADDR_SEC   = 3'd0,
    ADDR_MIN   = 3'd1,
    ADDR_HOUR  = 3'd2,
    ADDR_WDAY  = 3'd3,
    ADDR_DATE  = 3'd4,
    ADDR_MONTH = 3'd5,
    ADDR_YEAR  = 3'd6,
    ADDR_NONE  = 3'd7
  } rtc_addr_e;

  localparam int NUM_FIELDS = 7;
  localparam int CENT_BIT   = 6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) is_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       is_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      month_last = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input int i);
    case (i)
      0, 1:    field_mask = 8'h7F;
      2, 4:    field_mask = 8'h3F;
      3:       field_mask = 8'h07;
      5:       field_mask = 8'h1F;
      default: field_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] field_lo(input int i);
    field_lo = (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] field_hi(input int i);
    case (i)
      0, 1:    field_hi = 8'h59;
      2:       field_hi = 8'h23;
      3:       field_hi = 8'h07;
      4:       field_hi = 8'h31;
      5:       field_hi = 8'h12;
      default: field_hi = 8'h99;
    endcase
  endfunction

  // index of the field whose wrap advances field i (i > 0)
  function automatic int field_src(input int i);
    case (i)
      4:       field_src = 2;
      5:       field_src = 4;
      default: field_src = i - 1;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV   = 32768,
  parameter int CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o  = en_i && (cnt_q == LAST) && !clr_i;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (en_i) begin
      if (cnt_q == LAST)    cnt_q <= '0;
      else                  cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [7:0] MASK = 8'hFF,
  parameter logic [7:0] LO   = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_i,
  input  logic [7:0] wr_val_i,
  input  logic [7:0] hi_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);

  logic [7:0] val_q;
  logic       at_hi;

  assign at_hi  = (val_q == hi_i);
  assign wrap_o = adv_i && at_hi;
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= LO;
    else if (wr_i)   val_q <= wr_val_i & MASK;
    else if (adv_i)  val_q <= at_hi ? LO : (bcd_inc(val_q) & MASK);
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_32k_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o
);

  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             sec_tick;
  logic [CNT_W-1:0] presc_cnt;
  logic             wr_sec;
  logic [7:0]       fld_q [NUM_FIELDS];
  logic [7:0]       fld_hi [NUM_FIELDS];
  logic             fld_adv [NUM_FIELDS];
  logic             fld_wrap [NUM_FIELDS];
  logic [7:0]       date_last;
  logic             century_q;

  assign wr_sec = wr_en_i && (wr_addr_i == ADDR_SEC);

  rtc_prescaler #(.DIV(PRESCALE), .CNT_W(CNT_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tick_32k_i),
    .clr_i   (wr_sec),
    .tick_o  (sec_tick),
    .count_o (presc_cnt)
  );

  assign date_last = month_last(fld_q[ADDR_MONTH], is_leap(fld_q[ADDR_YEAR]));

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    if (i == 0) begin : g_root
      assign fld_adv[i] = sec_tick;
    end else begin : g_chain
      assign fld_adv[i] = fld_wrap[field_src(i)];
    end
    if (i == int'(ADDR_DATE)) begin : g_dyn
      assign fld_hi[i] = date_last;
    end else begin : g_fix
      assign fld_hi[i] = field_hi(i);
    end
    rtc_bcd_field #(.MASK(field_mask(i)), .LO(field_lo(i))) u_fld (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (fld_adv[i]),
      .wr_i     (wr_en_i && (wr_addr_i == 3'(i))),
      .wr_val_i (wr_data_i),
      .hi_i     (fld_hi[i]),
      .val_o    (fld_q[i]),
      .wrap_o   (fld_wrap[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    century_q <= 1'b0;
    else if (wr_en_i && (wr_addr_i == ADDR_HOUR))   century_q <= wr_data_i[CENT_BIT];
    else if (fld_wrap[ADDR_YEAR])                   century_q <= ~century_q;
  end

  always_comb begin
    case (rd_addr_i)
      ADDR_SEC:   rd_data_o = fld_q[ADDR_SEC];
      ADDR_MIN:   rd_data_o = fld_q[ADDR_MIN];
      ADDR_HOUR:  rd_data_o = {1'b0, century_q, fld_q[ADDR_HOUR][5:0]};
      ADDR_WDAY:  rd_data_o = fld_q[ADDR_WDAY];
      ADDR_DATE:  rd_data_o = fld_q[ADDR_DATE];
      ADDR_MONTH: rd_data_o = fld_q[ADDR_MONTH];
      ADDR_YEAR:  rd_data_o = fld_q[ADDR_YEAR];
      default:    rd_data_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sec_tick_i,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic [7:0]       wr_data_i,
  input logic [7:0]       sec_i,
  input logic [7:0]       min_i,
  input logic [7:0]       hour_i,
  input logic [7:0]       date_i,
  input logic [7:0]       month_i,
  input logic [7:0]       year_i,
  input logic             cent_i,
  input logic [CNT_W-1:0] presc_i
);

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && sec_i == 8'h59 && !wr_en_i) |=> (sec_i == 8'h00)); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick_i && !wr_en_i) |=> ($stable(sec_i) && $stable(min_i) && $stable(year_i) && $stable(cent_i))); // R2

  AST_WR_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd1) |=> (min_i == {1'b0, $past(wr_data_i[6:0])})); // R10

  AST_CENT_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && !wr_en_i && sec_i == 8'h59 && min_i == 8'h59 && hour_i == 8'h23 &&
     date_i == 8'h31 && month_i == 8'h12 && year_i == 8'h99) |=> (cent_i != $past(cent_i))); // R9

  AST_PRESC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0) |=> (presc_i == '0)); // R11

endmodule

bind rtc_calendar rtc_calendar_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sec_tick_i (sec_tick),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .sec_i      (fld_q[0]),
  .min_i      (fld_q[1]),
  .hour_i     (fld_q[2]),
  .date_i     (fld_q[4]),
  .month_i    (fld_q[5]),
  .year_i     (fld_q[6]),
  .cent_i     (century_q),
  .presc_i    (presc_cnt)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  rtc_calendar #(.PRESCALE(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_32k_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // behavioural reference model, binary integers
  int m_sec, m_min, m_hr, m_wd, m_dt, m_mo, m_yr, m_cent, m_pre;

  function automatic int b2i(input logic [7:0] b);
    return b[7:4] * 10 + b[3:0];
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_wd = 1; m_dt = 1; m_mo = 1;
      m_yr = 0; m_cent = 0; m_pre = 0;
    end else begin
      bit sec_w, t, c;
      int n_sec, n_min, n_hr, n_wd, n_dt, n_mo, n_yr, n_cent;
      sec_w = wr_en && wr_addr == 3'd0;
      t = tick && m_pre == DIV - 1 && !sec_w;
      if (sec_w) m_pre = 0;
      else if (tick) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      n_sec = m_sec; n_min = m_min; n_hr = m_hr; n_wd = m_wd;
      n_dt = m_dt; n_mo = m_mo; n_yr = m_yr; n_cent = m_cent;
      c = t;
      if (c) begin c = (m_sec == 59); n_sec = c ? 0 : m_sec + 1; end
      if (c) begin c = (m_min == 59); n_min = c ? 0 : m_min + 1; end
      if (c) begin c = (m_hr == 23);  n_hr  = c ? 0 : m_hr + 1; end
      if (c) begin
        n_wd = (m_wd == 7) ? 1 : m_wd + 1;
        c = (m_dt == days_in(m_mo, m_yr)); n_dt = c ? 1 : m_dt + 1;
      end
      if (c) begin c = (m_mo == 12); n_mo = c ? 1 : m_mo + 1; end
      if (c) begin c = (m_yr == 99); n_yr = c ? 0 : m_yr + 1; end
      if (c) n_cent = 1 - m_cent;
      if (wr_en) begin
        case (wr_addr)
          3'd0: n_sec = b2i(wr_data & 8'h7F);
          3'd1: n_min = b2i(wr_data & 8'h7F);
          3'd2: begin n_hr = b2i(wr_data & 8'h3F); n_cent = wr_data[6]; end
          3'd3: n_wd  = b2i(wr_data & 8'h07);
          3'd4: n_dt  = b2i(wr_data & 8'h3F);
          3'd5: n_mo  = b2i(wr_data & 8'h1F);
          3'd6: n_yr  = b2i(wr_data);
          default: ;
        endcase
      end
      m_sec = n_sec; m_min = n_min; m_hr = n_hr; m_wd = n_wd;
      m_dt = n_dt; m_mo = n_mo; m_yr = n_yr; m_cent = n_cent;
    end
  end

  function automatic logic [7:0] model_reg(input int a);
    case (a)
      0: return i2b(m_sec);
      1: return i2b(m_min);
      2: return i2b(m_hr) | (m_cent != 0 ? 8'h40 : 8'h00);
      3: return i2b(m_wd);
      4: return i2b(m_dt);
      5: return i2b(m_mo);
      6: return i2b(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 1: return "R3";
      2: return "R4/R9";
      3: return "R5";
      4: return "R6/R7";
      5, 6: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic read_reg(input int a, output logic [7:0] v);
    rd_addr = 3'(a);
    #1;
    v = rd_data;
  endtask

  // compare all registers at the falling edge, then drive the next inputs
  task automatic step(input bit t, input bit we, input logic [2:0] wa, input logic [7:0] wd);
    logic [7:0] v;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      read_reg(a, v);
      check(tag_of(a), v, model_reg(a));
    end
    tick = t; wr_en = we; wr_addr = wa; wr_data = wd;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) step((gap == 0) || (i % (gap + 1) == 0), 1'b0, 3'd0, 8'h00);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b1, 1'b1, a, d);
  endtask

  // set calendar; seconds last so the prescaler restarts on it
  task automatic set_all(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                         input logic [7:0] wd, input logic [7:0] hr, input logic [7:0] mi,
                         input logic [7:0] se);
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, wd);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
  endtask

  task automatic expect_reg(input int a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    @(negedge clk);
    read_reg(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R1 reset values
    expect_reg(0, 8'h00, "R1"); expect_reg(2, 8'h00, "R1");
    expect_reg(3, 8'h01, "R1"); expect_reg(4, 8'h01, "R1");
    expect_reg(5, 8'h01, "R1"); expect_reg(6, 8'h00, "R1");
    // R2 enable always high, then gated
    run(30, 0);
    run(30, 1);
    run(12, 3);
    // R3 R4 R5 R6 common year Feb 28 -> Mar 01, weekday 7 -> 1
    set_all(8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    run(12, 0);
    expect_reg(4, 8'h01, "R6"); expect_reg(5, 8'h03, "R6"); expect_reg(3, 8'h01, "R5");
    // R7 leap year 24
    set_all(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    run(6, 0);
    expect_reg(4, 8'h29, "R7");
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    run(6, 0);
    expect_reg(4, 8'h01, "R7"); expect_reg(5, 8'h03, "R7");
    // R7 year 00 is leap
    set_all(8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    run(6, 0);
    expect_reg(4, 8'h29, "R7");
    // R6 thirty-day month
    set_all(8'h11, 8'h04, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59);
    run(6, 0);
    expect_reg(5, 8'h05, "R6");
    // R8 R9 year and century rollover
    set_all(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h58);
    run(12, 0);
    expect_reg(6, 8'h00, "R8"); expect_reg(2, 8'h40, "R9");
    // R9 second rollover toggles back
    set_all(8'h99, 8'h12, 8'h31, 8'h05, 8'h63, 8'h59, 8'h59);
    run(6, 0);
    expect_reg(2, 8'h00, "R9");
    // R10 writes at various prescaler phases
    for (int k = 0; k < 8; k++) begin
      wr(3'd1, i2b(10 + k));
      run(k % 3, 0);
    end
    wr(3'd0, 8'h59);
    run(3, 0);
    wr(3'd1, 8'h07);
    run(1, 0);
    expect_reg(1, 8'h07, "R10");
    // R11 seconds write restarts the prescaler
    run(2, 0);
    wr(3'd0, 8'h10);
    run(3, 0);
    expect_reg(0, 8'h10, "R11");
    run(2, 0);
    expect_reg(0, 8'h11, "R11");
    // R12 unused address
    wr(3'd7, 8'hA5);
    run(1, 0);
    expect_reg(7, 8'h00, "R12");
    run(20, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule